// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a byte-wide command port and a flash array. It watches command writes and keeps a read mode that decides what a read returns: the array data supplied from outside, a two-byte identifier, or an internal status byte. A read mode stays in force until another recognised command is written. Writes of unrecognised bytes are ignored.

Block erase needs two writes: a setup byte followed by a confirm byte. A correct pair with the programming supply at its high level starts an erase engine. The engine is modelled here as a counter that runs for a parameterised number of cycles. A suspend request pauses the engine at the next check point inside that count. Array reads are then allowed, and a resume continues the count from where it stopped. A ready output is low only while the engine is actually counting. Failed erase attempts leave sticky error bits that software clears with a dedicated command.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array mode, `rd_data` equals `arr_rdata`, and `ready` is 1.
- R2: Writing 8'hFF outside an erase selects array mode, in which `rd_data` follows `arr_rdata`.
- R3: Writing 8'h90 selects identifier mode. A read at address 0 gives 8'h89, a read at address 1 gives 8'hA2, and any other address gives 8'h00. The mode persists until another recognised command is written.
- R4: Writing 8'h70 selects status mode. The status byte is laid out as follows: bit 7 is ready, bit 6 is suspended, bit 5 is erase error, bit 4 is write error, bit 3 is supply error, and bits 2:0 are 0.
- R5: Writing 8'h50 clears status bits 5:3 and leaves the read mode unchanged.
- R6: The pair 8'h20 then 8'hD0, with `vpp_hi`=1 and `vpp_lo`=0, starts an erase. Reads then return status. `ready` is low on exactly ERASE_CYCLES consecutive cycles, starting with the cycle after the confirm write.
- R7: The pair 8'h20 then 8'hD0 with the supply not at its high level starts no erase, sets status bit 3, and selects status mode.
- R8: The byte 8'h20 followed by any byte other than 8'hD0 starts no erase, sets status bits 5 and 4, and selects status mode.
- R9: While an erase is counting, only 8'h70 and 8'hB0 are accepted. Every other byte is ignored and reads keep returning status.
- R10: Writing 8'hB0 during an erase suspends it at the next check point, which is an engine count that is a multiple of CHK_INT. This happens within CHK_INT cycles. Once suspended, status bits 7 and 6 are 1 and `ready` is 1.
- R11: While suspended, only 8'hFF, 8'h70 and 8'hD0 are accepted. All other bytes are ignored.
- R12: Writing 8'hD0 while suspended resumes the erase. Status bits 7 and 6 clear and `ready` drops on the next cycle. The count continues from where it stopped, so the total number of low-`ready` cycles is ERASE_CYCLES plus one per suspension.
- R13: Unrecognised bytes written while idle leave the read mode and the status bits unchanged.
- R14: The identifier, status-read and clear-status commands work with the supply at either the high or the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe, sampled on the rising edge |
| cmd_data | input | 8 | Command byte |
| addr | input | ADDR_W | Byte address for writes and reads |
| vpp_hi | input | 1 | Programming supply is at the high level |
| vpp_lo | input | 1 | Programming supply is at the low level |
| arr_rdata | input | 8 | Data from the array at `addr` |
| rd_data | output | 8 | Read data for the current read mode |
| ready | output | 1 | 1 unless the erase engine is counting |

## Verification
A command write registers on the rising edge where `cmd_we` is high. The new read mode and status bits therefore show on `rd_data` during the following low clock phase, and the bench samples them there, one settle delay after the falling edge. `ready` falls on that same edge after a confirm. A free-running counter tallies low-`ready` samples at each falling edge, so the exact busy length (ERASE_CYCLES, or one more per suspension) is compared after the run rather than at a single guessed cycle. The suspend grant is polled edge by edge after the request, and it must show within CHK_INT samples.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_IDENT  = 2'd1,
      RM_STATUS = 2'd2,
      RM_SETUP  = 2'd3
   } rd_mode_e;

   localparam logic [7:0] OP_READ  = 8'hFF;
   localparam logic [7:0] OP_IDENT = 8'h90;
   localparam logic [7:0] OP_STAT  = 8'h70;
   localparam logic [7:0] OP_CLR   = 8'h50;
   localparam logic [7:0] OP_ERASE = 8'h20;
   localparam logic [7:0] OP_CONF  = 8'hD0;
   localparam logic [7:0] OP_SUSP  = 8'hB0;

   localparam logic [7:0] ID_MFR = 8'h89;
   localparam logic [7:0] ID_DEV = 8'hA2;

   typedef struct packed {
      logic erase_err;
      logic write_err;
      logic supply_err;
   } sticky_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
   import flash_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_i,
   input  logic [7:0] data_i,
   input  logic       supply_ok_i,
   input  logic       busy_i,
   input  logic       susp_i,
   output rd_mode_e   mode_o,
   output logic       start_o,
   output logic       susp_req_o,
   output logic       resume_o,
   output logic       set_ee_o,
   output logic       set_we_o,
   output logic       set_se_o,
   output logic       clr_o
);

   rd_mode_e mode_q, mode_d;

   always_comb begin
      mode_d     = mode_q;
      start_o    = 1'b0;
      susp_req_o = 1'b0;
      resume_o   = 1'b0;
      set_ee_o   = 1'b0;
      set_we_o   = 1'b0;
      set_se_o   = 1'b0;
      clr_o      = 1'b0;
      if (we_i) begin
         if (busy_i) begin
            if (data_i == OP_STAT)      mode_d = RM_STATUS;
            else if (data_i == OP_SUSP) susp_req_o = 1'b1;
         end else if (susp_i) begin
            if (data_i == OP_READ)      mode_d = RM_ARRAY;
            else if (data_i == OP_STAT) mode_d = RM_STATUS;
            else if (data_i == OP_CONF) begin
               resume_o = 1'b1;
               mode_d   = RM_STATUS;
            end
         end else if (mode_q == RM_SETUP) begin
            mode_d = RM_STATUS;
            if (data_i == OP_CONF) begin
               if (supply_ok_i) start_o  = 1'b1;
               else             set_se_o = 1'b1;
            end else begin
               set_ee_o = 1'b1;
               set_we_o = 1'b1;
            end
         end else begin
            case (data_i)
               OP_READ:  mode_d = RM_ARRAY;
               OP_IDENT: mode_d = RM_IDENT;
               OP_STAT:  mode_d = RM_STATUS;
               OP_CLR:   clr_o  = 1'b1;
               OP_ERASE: mode_d = RM_SETUP;
               default:  mode_d = mode_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= RM_ARRAY;
      else        mode_q <= mode_d;
   end

   assign mode_o = mode_q;

   // R9
   mode_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && we_i && data_i != OP_STAT) |=> $stable(mode_q));

endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine #(
   parameter int ERASE_CYCLES = 40,
   parameter int CHK_INT      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic susp_req_i,
   input  logic resume_i,
   output logic running_o,
   output logic susp_o
);

   localparam int CNT_W  = (ERASE_CYCLES > 2) ? $clog2(ERASE_CYCLES) : 1;
   localparam bit CHK_P2 = (CHK_INT & (CHK_INT - 1)) == 0;
   localparam int CHK_W  = (CHK_INT > 1) ? $clog2(CHK_INT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ERASE_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q, susp_q, pend_q;
   logic             at_chk;

   generate
      if (CHK_INT == 1) begin : g_chk_all
         assign at_chk = 1'b1;
      end else if (CHK_P2) begin : g_chk_mask
         assign at_chk = (cnt_q[CHK_W-1:0] == '0);
      end else begin : g_chk_mod
         assign at_chk = ((cnt_q % CNT_W'(CHK_INT)) == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         susp_q <= 1'b0;
         pend_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= '0;
         run_q  <= 1'b1;
         susp_q <= 1'b0;
         pend_q <= 1'b0;
      end else if (resume_i) begin
         susp_q <= 1'b0;
         pend_q <= 1'b0;
      end else if (run_q && !susp_q) begin
         if (susp_req_i) pend_q <= 1'b1;
         if (pend_q && at_chk) begin
            susp_q <= 1'b1;
         end else if (cnt_q == LAST) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign running_o = run_q;
   assign susp_o    = susp_q;

   // R10
   suspend_at_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp_q) |-> (at_chk && $stable(cnt_q) && run_q));

   // R12
   resume_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(susp_q) && run_q) |-> $stable(cnt_q));

   // R6
   count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= LAST));

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
   import flash_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ready_i,
   input  logic       susp_i,
   input  logic       set_ee_i,
   input  logic       set_we_i,
   input  logic       set_se_i,
   input  logic       clr_i,
   output logic [7:0] sr_o
);

   sticky_t err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= '0;
      end else if (clr_i) begin
         err_q <= '0;
      end else begin
         if (set_ee_i) err_q.erase_err  <= 1'b1;
         if (set_we_i) err_q.write_err  <= 1'b1;
         if (set_se_i) err_q.supply_err <= 1'b1;
      end
   end

   assign sr_o = {ready_i, susp_i, err_q.erase_err, err_q.write_err,
                  err_q.supply_err, 3'b000};

   // R5
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (err_q == '0));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int ERASE_CYCLES = 40,
   parameter int CHK_INT      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [7:0]        cmd_data,
   input  logic [ADDR_W-1:0] addr,
   input  logic              vpp_hi,
   input  logic              vpp_lo,
   input  logic [7:0]        arr_rdata,
   output logic [7:0]        rd_data,
   output logic              ready
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("flash_cmd_ctrl: ADDR_W must be at least 2");
      end
      if (ERASE_CYCLES < 2) begin : g_bad_len
         $error("flash_cmd_ctrl: ERASE_CYCLES must be at least 2");
      end
      if (CHK_INT < 1 || CHK_INT > ERASE_CYCLES) begin : g_bad_chk
         $error("flash_cmd_ctrl: CHK_INT must lie in 1..ERASE_CYCLES");
      end
   endgenerate

   rd_mode_e   mode;
   logic       supply_ok, running, susp, busy;
   logic       start, susp_req, resume;
   logic       set_ee, set_we, set_se, clr;
   logic [7:0] sr;

   assign supply_ok = vpp_hi & ~vpp_lo;
   assign busy      = running & ~susp;
   assign ready     = ~busy;

   flash_cmd_decode u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (cmd_we),
      .data_i      (cmd_data),
      .supply_ok_i (supply_ok),
      .busy_i      (busy),
      .susp_i      (susp),
      .mode_o      (mode),
      .start_o     (start),
      .susp_req_o  (susp_req),
      .resume_o    (resume),
      .set_ee_o    (set_ee),
      .set_we_o    (set_we),
      .set_se_o    (set_se),
      .clr_o       (clr)
   );

   flash_erase_engine #(
      .ERASE_CYCLES (ERASE_CYCLES),
      .CHK_INT      (CHK_INT)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .susp_req_i (susp_req),
      .resume_i   (resume),
      .running_o  (running),
      .susp_o     (susp)
   );

   flash_status_reg u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .ready_i  (ready),
      .susp_i   (susp),
      .set_ee_i (set_ee),
      .set_we_i (set_we),
      .set_se_i (set_se),
      .clr_i    (clr),
      .sr_o     (sr)
   );

   always_comb begin
      case (mode)
         RM_ARRAY: rd_data = arr_rdata;
         RM_IDENT: begin
            if (addr == ADDR_W'(0))      rd_data = ID_MFR;
            else if (addr == ADDR_W'(1)) rd_data = ID_DEV;
            else                         rd_data = 8'h00;
         end
         default:  rd_data = sr;
      endcase
   end

   // R9
   busy_reads_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (mode == RM_STATUS));

   // R6
   start_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (vpp_hi && !vpp_lo && ready));

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

   localparam int AW  = 20;
   localparam int N   = 40;
   localparam int CHK = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_we = 1'b0;
   logic [7:0]    cmd_data = 8'h00;
   logic [AW-1:0] addr = '0;
   logic          vpp_hi = 1'b1;
   logic          vpp_lo = 1'b0;
   logic [7:0]    arr_rdata = 8'h00;
   logic [7:0]    rd_data;
   logic          ready;

   int n_chk = 0, n_fail = 0;
   int busy_samples = 0;
   bit cnt_en = 1'b0;

   always #5 clk = ~clk;

   flash_cmd_ctrl #(.ADDR_W(AW), .ERASE_CYCLES(N), .CHK_INT(CHK)) u_flash_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
      .addr(addr), .vpp_hi(vpp_hi), .vpp_lo(vpp_lo), .arr_rdata(arr_rdata),
      .rd_data(rd_data), .ready(ready)
   );

   always @(negedge clk) if (cnt_en && ready === 1'b0) busy_samples++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      cmd_we = 1'b1; cmd_data = d;
      @(negedge clk);
      cmd_we = 1'b0;
      #1;
   endtask

   task automatic rd(input string req, input logic [AW-1:0] a,
                     input logic [7:0] arr, input logic [7:0] exp);
      addr = a; arr_rdata = arr;
      #1;
      chk(req, rd_data, exp);
   endtask

   function automatic logic [7:0] exp_sr(input bit rdy, input bit sus, input logic [2:0] err);
      return {rdy, sus, err, 3'b000};
   endfunction

   // mode: 0 array, 1 ident, 2 status (setup pending also reads status)
   function automatic logic [7:0] exp_rd(input int mode, input logic [2:0] err,
                                         input logic [AW-1:0] a, input logic [7:0] arr);
      if (mode == 0) return arr;
      if (mode == 1) return (a == 0) ? 8'h89 : (a == 1) ? 8'hA2 : 8'h00;
      return exp_sr(1'b1, 1'b0, err);
   endfunction

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      int m_mode;
      bit m_setup;
      logic [2:0] m_err;
      int waited;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 ready", ready, 1);
      rd("R1 array", 5, 8'h3C, 8'h3C);

      // R13 unknown byte in array mode
      wr(8'h33);
      rd("R13 array kept", 7, 8'h5A, 8'h5A);

      // R3 identifier
      wr(8'h90);
      rd("R3 mfr", 0, 8'h11, 8'h89);
      rd("R3 dev", 1, 8'h11, 8'hA2);
      rd("R3 other", 2, 8'h11, 8'h00);
      // R5 clear leaves mode
      wr(8'h50);
      rd("R5 ident kept", 0, 8'h11, 8'h89);
      // R2 array
      wr(8'hFF);
      rd("R2 array", 9, 8'hC3, 8'hC3);
      // R4 status
      wr(8'h70);
      rd("R4 status idle", 0, 8'h00, 8'h80);
      // R13 unknown byte in status mode
      wr(8'h44);
      rd("R13 status kept", 0, 8'h00, 8'h80);
      // R8 bad confirm
      wr(8'h20);
      wr(8'h55);
      rd("R8 errors", 0, 8'h00, 8'hB0);
      chk("R8 no erase", ready, 1);
      // R5 clear
      wr(8'h50);
      rd("R5 cleared", 0, 8'h00, 8'h80);

      // R7 low supply
      vpp_hi = 1'b0; vpp_lo = 1'b1;
      wr(8'h20);
      wr(8'hD0);
      rd("R7 supply err", 0, 8'h00, 8'h88);
      chk("R7 no erase", ready, 1);
      // R14 commands at low supply
      wr(8'h90);
      rd("R14 ident low", 1, 8'h00, 8'hA2);
      wr(8'h70);
      rd("R14 status low", 0, 8'h00, 8'h88);
      wr(8'h50);
      rd("R14 clear low", 0, 8'h00, 8'h80);
      vpp_hi = 1'b1; vpp_lo = 1'b0;

      // R6 erase without suspend, R9 ignored commands while busy
      wr(8'hFF);
      busy_samples = 0; cnt_en = 1'b1;
      wr(8'h20);
      wr(8'hD0);
      chk("R6 ready low after confirm", ready, 0);
      rd("R6 status busy", 0, 8'h77, 8'h00);
      wr(8'hFF);
      rd("R9 FF ignored", 0, 8'h77, 8'h00);
      wr(8'h50);
      wr(8'h90);
      rd("R9 ident ignored", 0, 8'h77, 8'h00);
      repeat (N + 4) @(negedge clk);
      #1;
      chk("R6 busy length", busy_samples, N);
      chk("R6 ready after", ready, 1);
      rd("R6 done status", 0, 8'h00, 8'h80);
      cnt_en = 1'b0;

      // R10 / R11 / R12 suspend and resume
      busy_samples = 0; cnt_en = 1'b1;
      wr(8'h20);
      wr(8'hD0);
      repeat (3) @(negedge clk);
      wr(8'hB0);
      waited = 0;
      while (ready !== 1'b1 && waited < CHK + 3) begin
         @(negedge clk); #1;
         waited++;
      end
      chk("R10 suspend latency ok", (waited <= CHK), 1);
      rd("R10 suspended status", 0, 8'h00, 8'hC0);
      wr(8'h90);
      rd("R11 ident ignored", 0, 8'h00, 8'hC0);
      wr(8'h50);
      rd("R11 clear ignored", 0, 8'h00, 8'hC0);
      wr(8'hFF);
      rd("R11 array read", 3, 8'h6E, 8'h6E);
      wr(8'h70);
      rd("R11 status read", 0, 8'h00, 8'hC0);
      wr(8'hD0);
      chk("R12 ready low", ready, 0);
      rd("R12 status resumed", 0, 8'h00, 8'h00);
      waited = 0;
      while (ready !== 1'b1 && waited < N + 4) begin
         @(negedge clk); #1;
         waited++;
      end
      chk("R12 busy total", busy_samples, N + 1);
      rd("R12 done status", 0, 8'h00, 8'h80);
      cnt_en = 1'b0;

      // Random phase, no erase starts: R2 R3 R4 R5 R7 R8 R13 R14
      wr(8'hFF);
      wr(8'h50);
      m_mode = 0; m_setup = 1'b0; m_err = 3'b000;
      for (int i = 0; i < 300; i++) begin
         logic [7:0] ops [9];
         logic [7:0] d;
         logic [AW-1:0] a;
         logic [7:0] arr;
         int v;
         ops = '{8'hFF, 8'h90, 8'h70, 8'h50, 8'h20, 8'hD0, 8'hB0, 8'h20, 8'h00};
         d = ops[$urandom % 9];
         if (d == 8'h00) d = 8'($urandom);
         v = $urandom % 3;
         vpp_hi = (v == 0); vpp_lo = (v == 1);
         if (m_setup && d == 8'hD0 && vpp_hi) vpp_lo = 1'b1;
         if (m_setup) begin
            m_setup = 1'b0; m_mode = 2;
            if (d == 8'hD0) m_err[0] = 1'b1;
            else            m_err[2:1] = 2'b11;
         end else begin
            case (d)
               8'hFF: m_mode = 0;
               8'h90: m_mode = 1;
               8'h70: m_mode = 2;
               8'h50: m_err = 3'b000;
               8'h20: begin m_setup = 1'b1; m_mode = 2; end
               default: ;
            endcase
         end
         wr(d);
         chk("R13 random ready", ready, 1);
         a = AW'($urandom % 4);
         arr = 8'($urandom);
         rd("R2 R3 R4 R5 R7 R8 random read", a, arr, exp_rd(m_mode, m_err, a, arr));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule